// File: doc/BRIEF.md
# Rotating register window controller

This block keeps the bookkeeping for a call-window calling convention. It holds a physical file of `NAREG` 32-bit registers. A window-base pointer counts in groups of four registers. A window-start bitmap has one bit per group and marks the groups that begin a live frame. Sixteen logical registers are seen through the window: logical register r is physical register (base*4 + r) modulo `NAREG`. The base wraps modulo `NAREG`/4.

The pipeline issues one command per cycle:

- **Call entry**: allocate a frame.
- **Windowed return**.
- **Rotate**: relative move of the base.
- **Base write**: absolute move of the base.
- **Window-start write**.
- **Stack-move check**.

Each command's result comes back one cycle later. The result is success, an illegal-instruction trap, an alloca trap, or a window overflow or underflow of 4, 8 or 12 registers. The surrounding core owns the status word. It supplies the window-overflow-enable bit, the exception-mode bit and the call increment. On a trap it uses the returned old base and PC to set exception mode and enter the spill or fill handler. The handler code itself lies outside this block.

A single combinational read port and a write port give access to the logical registers through the current window.

Top module: `win_reg_ctrl`

## Requirements
- R1: After reset the base is 0, the window-start bitmap is ...0001 (only group 0 marked), every physical register reads 0, and `res_valid_o` is 0.
- R2: `rd_data_o` shows physical register (base*4 + `rd_idx_i`) mod NAREG. A port write with `wr_en_i` goes to the same mapping. Rotate (op 2) adds the signed 4-bit `cmd_arg_i[3:0]` to the base. Base write (op 3) loads `cmd_arg_i` modulo NAREG/4.
- R3: A command on `cmd_valid_i` gives exactly one `res_valid_o` pulse on the next cycle, and no pulse follows a cycle without a command. Result codes are: 0 ok, 1 illegal, 2 alloca, 3/4/5 overflow 4/8/12, 6/7/8 underflow 4/8/12. `res_owb_o` is the base before the command. `res_pc_o` is `cmd_pc_i` unless R8 gives a return target.
- R4: Call entry (op 0) is illegal if `cmd_s_i` > 3, or if `ps_woe_i` is 0, or if `ps_excm_i` is 1. An illegal call entry changes no state.
- R5: For a legal call entry with increment ci, let bit k of S be the window-start bit of group base+1+k. If any of S[ci-1:0] is set, the call entry overflows. Let n be the index of the lowest set bit of S, plus 1. The base advances by n and no register is written. The code is overflow-4 if S[n] is set, else overflow-8 if S[n+1] is set, else overflow-12.
- R6: A legal call entry without overflow does three things. It writes logical register s minus (`cmd_arg_i[11:0]` * 8) into logical register ci*4+s. It advances the base by ci. It sets the window-start bit of the new base.
- R7: Return (op 1) takes n from bits 31:30 of logical register 0. It takes m as the smallest of 1..3 whose window-start bit at base-m is set, or 0 if none is set. The return is illegal, with no state change, if n = 0, or if m ≠ 0 and m ≠ n, or if the R4 mode check fails.
- R8: A legal return moves the base back by n. It reports the target {`cmd_pc_i`[31:30], r0[29:0]} on `res_pc_o`. If the window-start bit at the new base is set, it clears the bit of the old base and returns code 0.
- R9: If that bit is clear, the return reports underflow-4/8/12 for n = 1/2/3. The base is still moved back and the bitmap is left unchanged.
- R10: The stack-move check (op 4) returns alloca when the window-start bits at base-1, base-2 and base-3 are all clear. Otherwise it returns 0. It never changes state, and no other op returns alloca.
- R11: Window-start write (op 5) loads the bitmap from `cmd_arg_i[NAREG/4-1:0]`. Ops 6 and 7 return illegal and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command opcode |
| cmd_s_i | input | 4 | Call-entry register operand |
| cmd_arg_i | input | 32 | Immediate, rotate amount, base value or bitmap |
| cmd_pc_i | input | 32 | PC of the command |
| ps_woe_i | input | 1 | Window overflow enable from status word |
| ps_excm_i | input | 1 | Exception mode from status word |
| ps_callinc_i | input | 2 | Call increment from status word |
| rd_idx_i | input | 4 | Logical read index |
| rd_data_o | output | 32 | Logical read data |
| wr_en_i | input | 1 | Logical write enable |
| wr_idx_i | input | 4 | Logical write index |
| wr_data_i | input | 32 | Logical write data |
| res_valid_o | output | 1 | Result strobe |
| res_code_o | output | 4 | Result code |
| res_pc_o | output | 32 | Return target or command PC |
| res_owb_o | output | log2(NAREG/4) | Base before the command |
| wbase_o | output | log2(NAREG/4) | Current window base |
| wstart_o | output | NAREG/4 | Current window-start bitmap |

## Verification
The hardest results to reach are the overflow-8 and overflow-12 codes and the underflow codes. They need a bitmap whose marked groups sit at particular distances from the base. Normal nested call entries only ever produce the overflow-4 pattern when the file wraps. The stimulus therefore writes hand-picked bitmaps with op 5 and places the base with op 3. It loads logical register 0 with a chosen return size before each return. After that, a long pseudo-random mix of all commands and register writes is compared cycle by cycle against a behavioural model.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [2:0] {
    OP_ENTRY  = 3'd0,
    OP_RETW   = 3'd1,
    OP_ROTW   = 3'd2,
    OP_WBASE  = 3'd3,
    OP_MOVSP  = 3'd4,
    OP_WSTART = 3'd5
  } win_op_e;

  typedef enum logic [3:0] {
    RES_OK      = 4'd0,
    RES_ILLEGAL = 4'd1,
    RES_ALLOCA  = 4'd2,
    RES_OVF4    = 4'd3,
    RES_OVF8    = 4'd4,
    RES_OVF12   = 4'd5,
    RES_UNF4    = 4'd6,
    RES_UNF8    = 4'd7,
    RES_UNF12   = 4'd8
  } win_res_e;
endpackage

// File: rtl/win_map.sv
module win_map #(
  parameter int GW = 3,
  localparam int AW = GW + 2
) (
  input  logic [GW-1:0] base_i,
  input  logic [3:0]    lidx_i,
  output logic [AW-1:0] pidx_o
);
  // modulo NAREG falls out of the AW-bit truncation
  assign pidx_o = {base_i, 2'b00} + AW'(lidx_i);
endmodule

// File: rtl/win_scan.sv
module win_scan
  import win_pkg::*;
#(
  parameter int NG = 8,
  localparam int GW = $clog2(NG)
) (
  input  logic [NG-1:0] ws_i,
  input  logic [GW-1:0] base_i,
  input  logic [1:0]    callinc_i,
  output logic          ovf_hit_o,
  output logic [1:0]    ovf_n_o,
  output win_res_e      ovf_code_o,
  output logic [1:0]    ret_m_o
);
  logic [4:0] above;
  logic [3:1] below;
  logic [2:0] ci_mask;
  logic [2:0] n_idx;

  for (genvar k = 0; k < 5; k++) begin : g_above
    assign above[k] = ws_i[base_i + GW'(k + 1)];
  end
  for (genvar k = 1; k < 4; k++) begin : g_below
    assign below[k] = ws_i[base_i - GW'(k)];
  end

  always_comb begin
    unique case (callinc_i)
      2'd0:    ci_mask = 3'b000;
      2'd1:    ci_mask = 3'b001;
      2'd2:    ci_mask = 3'b011;
      default: ci_mask = 3'b111;
    endcase
    ovf_hit_o = |(above[2:0] & ci_mask);
    if (above[0])      ovf_n_o = 2'd1;
    else if (above[1]) ovf_n_o = 2'd2;
    else               ovf_n_o = 2'd3;
    n_idx = {1'b0, ovf_n_o};
    if (above[n_idx])               ovf_code_o = RES_OVF4;
    else if (above[n_idx + 3'd1])   ovf_code_o = RES_OVF8;
    else                            ovf_code_o = RES_OVF12;
    if (below[1])      ret_m_o = 2'd1;
    else if (below[2]) ret_m_o = 2'd2;
    else if (below[3]) ret_m_o = 2'd3;
    else               ret_m_o = 2'd0;
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NAREG = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NAREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][31:0]     rdata_o,
  input  logic                     wa_en_i,
  input  logic [AW-1:0]            wa_addr_i,
  input  logic [31:0]              wa_data_i,
  input  logic                     wb_en_i,
  input  logic [AW-1:0]            wb_addr_i,
  input  logic [31:0]              wb_data_i
);
  logic [31:0] mem_q [NAREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NAREG; i++) mem_q[i] <= '0;
    end else begin
      if (wa_en_i) mem_q[wa_addr_i] <= wa_data_i;
      if (wb_en_i) mem_q[wb_addr_i] <= wb_data_i;  // port b wins on a clash
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/win_reg_ctrl.sv
module win_reg_ctrl
  import win_pkg::*;
#(
  parameter int  NAREG = 32,
  localparam int NG    = NAREG / 4,
  localparam int GW    = $clog2(NG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [3:0]    cmd_s_i,
  input  logic [31:0]   cmd_arg_i,
  input  logic [31:0]   cmd_pc_i,
  input  logic          ps_woe_i,
  input  logic          ps_excm_i,
  input  logic [1:0]    ps_callinc_i,
  input  logic [3:0]    rd_idx_i,
  output logic [31:0]   rd_data_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_idx_i,
  input  logic [31:0]   wr_data_i,
  output logic          res_valid_o,
  output logic [3:0]    res_code_o,
  output logic [31:0]   res_pc_o,
  output logic [GW-1:0] res_owb_o,
  output logic [GW-1:0] wbase_o,
  output logic [NG-1:0] wstart_o
);
  localparam int AW   = GW + 2;
  localparam int NMAP = 5;
  localparam int NRD  = 3;

  logic [GW-1:0] base_q, base_d;
  logic [NG-1:0] ws_q, ws_d;
  logic          res_valid_q;
  win_res_e      code_d, code_q;
  logic [31:0]   pc_d, pc_q;
  logic [GW-1:0] owb_q;

  // map slots: 0 read, 1 port write, 2 entry source, 3 entry dest, 4 r0
  logic [NMAP-1:0][3:0]    lidx;
  logic [NMAP-1:0][AW-1:0] pidx;
  logic [NRD-1:0][AW-1:0]  raddr;
  logic [NRD-1:0][31:0]    rdata;

  assign lidx[0] = rd_idx_i;
  assign lidx[1] = wr_idx_i;
  assign lidx[2] = cmd_s_i;
  assign lidx[3] = {ps_callinc_i, cmd_s_i[1:0]};
  assign lidx[4] = 4'd0;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    win_map #(.GW(GW)) u_map (.base_i(base_q), .lidx_i(lidx[g]), .pidx_o(pidx[g]));
  end

  assign raddr = {pidx[4], pidx[2], pidx[0]};

  logic        ent_we;
  logic [31:0] ent_data;

  win_regfile #(.NAREG(NAREG), .NRD(NRD)) u_rf (
    .clk_i, .rst_ni,
    .raddr_i  (raddr),
    .rdata_o  (rdata),
    .wa_en_i  (wr_en_i),
    .wa_addr_i(pidx[1]),
    .wa_data_i(wr_data_i),
    .wb_en_i  (ent_we),
    .wb_addr_i(pidx[3]),
    .wb_data_i(ent_data)
  );

  assign rd_data_o = rdata[0];
  assign ent_data  = rdata[1] - 32'({cmd_arg_i[11:0], 3'b000});

  logic          ovf_hit;
  logic [1:0]    ovf_n;
  win_res_e      ovf_code;
  logic [1:0]    ret_m;

  win_scan #(.NG(NG)) u_scan (
    .ws_i(ws_q), .base_i(base_q), .callinc_i(ps_callinc_i),
    .ovf_hit_o(ovf_hit), .ovf_n_o(ovf_n), .ovf_code_o(ovf_code), .ret_m_o(ret_m)
  );

  logic        mode_ok;
  logic [1:0]  ret_n;
  logic signed [31:0] rot_delta;
  logic        unused_bits;

  assign mode_ok     = ps_woe_i & ~ps_excm_i;
  assign ret_n       = rdata[2][31:30];
  assign rot_delta   = 32'(signed'(cmd_arg_i[3:0]));
  assign unused_bits = ^{cmd_arg_i[31:12], rot_delta[31:4]};

  always_comb begin
    base_d = base_q;
    ws_d   = ws_q;
    code_d = RES_OK;
    pc_d   = cmd_pc_i;
    ent_we = 1'b0;
    if (cmd_valid_i) begin
      unique case (cmd_op_i)
        OP_ENTRY: begin
          if (cmd_s_i > 4'd3 || !mode_ok) begin
            code_d = RES_ILLEGAL;
          end else if (ovf_hit) begin
            base_d = base_q + GW'(ovf_n);
            code_d = ovf_code;
          end else begin
            ent_we = 1'b1;
            base_d = base_q + GW'(ps_callinc_i);
            ws_d   = ws_q | (NG'(1) << base_d);
          end
        end
        OP_RETW: begin
          if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !mode_ok) begin
            code_d = RES_ILLEGAL;
          end else begin
            pc_d   = {cmd_pc_i[31:30], rdata[2][29:0]};
            base_d = base_q - GW'(ret_n);
            if (ws_q[base_d]) begin
              ws_d = ws_q & ~(NG'(1) << base_q);
            end else begin
              unique case (ret_n)
                2'd1:    code_d = RES_UNF4;
                2'd2:    code_d = RES_UNF8;
                default: code_d = RES_UNF12;
              endcase
            end
          end
        end
        OP_ROTW:   base_d = base_q + GW'(rot_delta);
        OP_WBASE:  base_d = cmd_arg_i[GW-1:0];
        OP_MOVSP:  if (ret_m == 2'd0) code_d = RES_ALLOCA;
        OP_WSTART: ws_d = cmd_arg_i[NG-1:0];
        default:   code_d = RES_ILLEGAL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      ws_q        <= NG'(1);
      res_valid_q <= 1'b0;
      code_q      <= RES_OK;
      pc_q        <= '0;
      owb_q       <= '0;
    end else begin
      base_q      <= base_d;
      ws_q        <= ws_d;
      res_valid_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        code_q <= code_d;
        pc_q   <= pc_d;
        owb_q  <= base_q;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_code_o  = code_q;
  assign res_pc_o    = pc_q;
  assign res_owb_o   = owb_q;
  assign wbase_o     = base_q;
  assign wstart_o    = ws_q;
endmodule

// File: rtl/win_reg_ctrl_chk.sv
module win_reg_ctrl_chk
  import win_pkg::*;
#(
  parameter int  NAREG = 32,
  localparam int NG    = NAREG / 4,
  localparam int GW    = $clog2(NG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic [3:0]    cmd_s_i,
  input logic          res_valid_o,
  input logic [3:0]    res_code_o,
  input logic [GW-1:0] res_owb_o,
  input logic [GW-1:0] wbase_o,
  input logic [NG-1:0] wstart_o
);
  initial begin
    AST_NAREG_LEGAL: assert (NAREG >= 32 && NAREG <= 64 && (NAREG & (NAREG - 1)) == 0); // R2
  end

  AST_RES_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> res_valid_o); // R3
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !res_valid_o); // R3
  AST_ENTRY_BAD_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_ENTRY && cmd_s_i > 4'd3)
      |=> (res_code_o == RES_ILLEGAL && $stable(wbase_o) && $stable(wstart_o))); // R4
  AST_OVF_MOVES_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && (res_code_o == RES_OVF4 || res_code_o == RES_OVF8 || res_code_o == RES_OVF12))
      |-> (wbase_o != res_owb_o)); // R5
  AST_ENTRY_MARKS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_ENTRY)
      |=> (res_code_o != RES_OK || wstart_o[wbase_o])); // R6
  AST_UNF_KEEPS_BITMAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_RETW)
      |=> ((res_code_o != RES_UNF4 && res_code_o != RES_UNF8 && res_code_o != RES_UNF12)
           || $stable(wstart_o))); // R9
  AST_MOVSP_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_MOVSP) |=> ($stable(wbase_o) && $stable(wstart_o))); // R10
  AST_ALLOCA_ONLY_MOVSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i != OP_MOVSP) |=> (res_code_o != RES_ALLOCA)); // R10
endmodule

bind win_reg_ctrl win_reg_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_s_i(cmd_s_i), .res_valid_o(res_valid_o), .res_code_o(res_code_o),
  .res_owb_o(res_owb_o), .wbase_o(wbase_o), .wstart_o(wstart_o)
);

// File: tb/tb_win_reg_ctrl.sv
module tb_win_reg_ctrl;
  localparam int CLK_PERIOD = 40;
  localparam int NAREG = 32;
  localparam int NG = NAREG / 4;
  localparam int GW = $clog2(NG);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [3:0]    cmd_s = '0;
  logic [31:0]   cmd_arg = '0;
  logic [31:0]   cmd_pc = '0;
  logic          woe = 1'b1;
  logic          excm = 1'b0;
  logic [1:0]    callinc = '0;
  logic [3:0]    rd_idx = '0;
  logic [31:0]   rd_data;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic          res_valid;
  logic [3:0]    res_code;
  logic [31:0]   res_pc;
  logic [GW-1:0] res_owb;
  logic [GW-1:0] wbase;
  logic [NG-1:0] wstart;

  always #(CLK_PERIOD / 2) clk = ~clk;

  win_reg_ctrl #(.NAREG(NAREG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_s_i(cmd_s), .cmd_arg_i(cmd_arg), .cmd_pc_i(cmd_pc), .ps_woe_i(woe),
    .ps_excm_i(excm), .ps_callinc_i(callinc), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .res_valid_o(res_valid),
    .res_code_o(res_code), .res_pc_o(res_pc), .res_owb_o(res_owb), .wbase_o(wbase),
    .wstart_o(wstart)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [31:0] m_phys [NAREG];
  int          m_base;
  logic [NG-1:0] m_ws;
  int          exp_code;
  logic [31:0] exp_pc;
  int          exp_owb;
  string       tag;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int wrap(int v, int m);
    return ((v % m) + m) % m;
  endfunction

  function automatic int phys_of(int r);
    return wrap(m_base * 4 + r, NAREG);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "wbase", 32'(wbase), 32'(m_base));
    chk(req, "wstart", 32'(wstart), 32'(m_ws));
    for (int r = 0; r < 16; r++) begin
      rd_idx = 4'(r);
      #1;
      chk("R2", "logical register", rd_data, m_phys[phys_of(r)]);
    end
  endtask

  task automatic model_cmd(int op, int s, logic [31:0] arg, logic [31:0] pc, bit w, bit x, int ci);
    int ob;
    bit legal;
    ob = m_base;
    legal = w && !x;
    exp_owb = ob;
    exp_pc = pc;
    exp_code = 0;
    case (op)
      0: begin
        if (s > 3 || !legal) begin
          exp_code = 1; tag = "R4";
        end else begin
          int first;
          first = 0;
          for (int k = 1; k <= ci; k++)
            if (first == 0 && m_ws[wrap(ob + k, NG)]) first = k;
          if (first != 0) begin
            int j;
            j = 0;
            while (j < 2 && !m_ws[wrap(ob + 1 + first + j, NG)]) j++;
            exp_code = 3 + j;
            m_base = wrap(ob + first, NG);
            tag = "R5";
          end else begin
            logic [31:0] src;
            src = m_phys[wrap(ob * 4 + s, NAREG)];
            m_phys[wrap(ob * 4 + ci * 4 + s, NAREG)] = src - (32'(arg[11:0]) * 32'd8);
            m_base = wrap(ob + ci, NG);
            m_ws[m_base] = 1'b1;
            tag = "R6";
          end
        end
      end
      1: begin
        logic [31:0] r0;
        int n, m;
        r0 = m_phys[wrap(ob * 4, NAREG)];
        n = int'(r0[31:30]);
        m = 0;
        for (int k = 1; k <= 3; k++)
          if (m == 0 && m_ws[wrap(ob - k, NG)]) m = k;
        if (n == 0 || (m != 0 && m != n) || !legal) begin
          exp_code = 1; tag = "R7";
        end else begin
          int nb;
          exp_pc = {pc[31:30], r0[29:0]};
          nb = wrap(ob - n, NG);
          m_base = nb;
          if (m_ws[nb]) begin
            m_ws[ob] = 1'b0; tag = "R8";
          end else begin
            exp_code = 5 + n; tag = "R9";
          end
        end
      end
      2: begin
        int d;
        d = int'(arg[3:0]);
        if (d >= 8) d = d - 16;
        m_base = wrap(ob + d, NG);
        tag = "R2";
      end
      3: begin m_base = int'(arg) & (NG - 1); tag = "R2"; end
      4: begin
        if (!m_ws[wrap(ob - 1, NG)] && !m_ws[wrap(ob - 2, NG)] && !m_ws[wrap(ob - 3, NG)])
          exp_code = 2;
        tag = "R10";
      end
      5: begin m_ws = arg[NG-1:0]; tag = "R11"; end
      default: begin exp_code = 1; tag = "R11"; end
    endcase
  endtask

  task automatic run_cmd(int op, int s, logic [31:0] arg, logic [31:0] pc, bit w, bit x, int ci);
    cmd_valid = 1'b1;
    cmd_op = 3'(op);
    cmd_s = 4'(s);
    cmd_arg = arg;
    cmd_pc = pc;
    woe = w;
    excm = x;
    callinc = 2'(ci);
    model_cmd(op, s, arg, pc, w, x, ci);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3", "res_valid after command", 32'(res_valid), 32'd1);
    chk(tag, "result code", 32'(res_code), 32'(exp_code));
    chk(tag, "result pc", res_pc, exp_pc);
    chk("R3", "old base", 32'(res_owb), 32'(exp_owb));
    check_state(tag);
  endtask

  task automatic write_reg(int idx, logic [31:0] d);
    wr_en = 1'b1;
    wr_idx = 4'(idx);
    wr_data = d;
    m_phys[phys_of(idx)] = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3", "res_valid idle", 32'(res_valid), 32'd0);
    check_state("R2");
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NAREG; i++) m_phys[i] = '0;
    m_base = 0;
    m_ws = NG'(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "res_valid reset", 32'(res_valid), 32'd0);
    chk("R1", "wbase reset", 32'(wbase), 32'd0);
    chk("R1", "wstart reset", 32'(wstart), 32'd1);
    check_state("R1");

    for (int r = 0; r < 16; r++) write_reg(r, 32'h1000_0000 + 32'(r) * 32'h111);

    // nested call entries until the file wraps: R6 then R5 overflow-4
    for (int i = 0; i < 9; i++) run_cmd(0, 1, 32'd2, 32'h4000_0100 + 32'(i), 1, 0, 1);

    // crafted bitmaps for overflow sizes (R5)
    run_cmd(5, 0, 32'b0000_0101, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd0, 32'h0, 1, 0, 0);
    run_cmd(0, 2, 32'd5, 32'h8000_0010, 1, 0, 3);
    run_cmd(5, 0, 32'b0001_0101, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd0, 32'h0, 1, 0, 0);
    run_cmd(0, 2, 32'd5, 32'h8000_0020, 1, 0, 3);
    run_cmd(5, 0, 32'b0000_0111, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd0, 32'h0, 1, 0, 0);
    run_cmd(0, 0, 32'd1, 32'h8000_0030, 1, 0, 1);

    // R4 illegal call entries
    run_cmd(0, 4, 32'd1, 32'h50, 1, 0, 1);
    run_cmd(0, 1, 32'd1, 32'h54, 1, 1, 1);
    run_cmd(0, 1, 32'd1, 32'h58, 0, 0, 1);

    // R8 successful return
    run_cmd(5, 0, 32'b0000_0011, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd1, 32'h0, 1, 0, 0);
    write_reg(0, {2'b01, 30'h0000_0123});
    run_cmd(1, 0, 32'd0, 32'hC000_0400, 1, 0, 0);

    // R9 underflow of each size
    for (int n = 1; n <= 3; n++) begin
      run_cmd(5, 0, 32'b1000_0000, 32'h0, 1, 0, 0);
      run_cmd(3, 0, 32'd4, 32'h0, 1, 0, 0);
      write_reg(0, {2'(n), 30'h0ABC_DEF0});
      run_cmd(1, 0, 32'd0, 32'h4000_0800, 1, 0, 0);
    end

    // R7 illegal returns
    run_cmd(5, 0, 32'b0000_1000, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd4, 32'h0, 1, 0, 0);
    write_reg(0, 32'h0000_0042);
    run_cmd(1, 0, 32'd0, 32'h900, 1, 0, 0);
    write_reg(0, 32'h8000_0042);
    run_cmd(1, 0, 32'd0, 32'h904, 1, 0, 0);
    write_reg(0, 32'h4000_0042);
    run_cmd(1, 0, 32'd0, 32'h908, 1, 1, 0);

    // R10 stack-move check
    run_cmd(5, 0, 32'b0000_1000, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd3, 32'h0, 1, 0, 0);
    run_cmd(4, 0, 32'd0, 32'hA00, 1, 0, 0);
    run_cmd(5, 0, 32'b0000_1001, 32'h0, 1, 0, 0);
    run_cmd(4, 0, 32'd0, 32'hA04, 1, 0, 0);

    // R2 rotate and base write wrap
    run_cmd(3, 0, 32'd0, 32'h0, 1, 0, 0);
    run_cmd(2, 0, 32'h0000_000F, 32'h0, 1, 0, 0);
    run_cmd(2, 0, 32'h0000_0007, 32'h0, 1, 0, 0);
    run_cmd(3, 0, 32'd13, 32'h0, 1, 0, 0);

    // R11 undefined opcodes
    run_cmd(6, 0, 32'hFFFF_FFFF, 32'hB00, 1, 0, 0);
    run_cmd(7, 0, 32'hFFFF_FFFF, 32'hB04, 1, 0, 0);

    // pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r, a;
      int kind;
      bit w, x;
      r = next_rand();
      a = next_rand();
      kind = int'(r % 12);
      w = (r[7:5] != 3'd0);
      x = (r[10:8] == 3'd0);
      case (kind)
        0, 1:    write_reg(int'(r[15:12]), a);
        2, 3, 4: run_cmd(0, int'(r[18:16]) % 5, a, a ^ r, w, x, int'(r[20:19]));
        5, 6:    run_cmd(1, 0, a, r, w, x, 0);
        7:       run_cmd(2, 0, a, r, w, x, 0);
        8:       run_cmd(4, 0, a, r, w, x, 0);
        9:       run_cmd(5, 0, a, r, w, x, 0);
        10:      run_cmd(3, 0, a, r, w, x, 0);
        default: run_cmd(int'(r[23:21]), 0, a, r, w, x, int'(r[25:24]));
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule